// File: doc/BRIEF.md
# Odd-Parity Serial Frame Receiver

This block turns an asynchronous serial line into bytes. The line rests high. A frame opens with a low start bit and carries eight data bits, least significant first. An odd-parity bit comes next: it makes the total count of ones across the data and parity bits odd, so byte 0x00 travels with parity 1 and byte 0x07 with parity 0. A high stop bit closes the frame. Any length of idle time may separate frames, and a new frame may also follow its stop bit at once.

The raw line first passes through a synchronizer of `SYNC_STAGES` flops. While the receiver is idle, a low level on the synchronized line starts a frame. The receiver samples the line again half a bit later to confirm the start bit. After that it samples each following bit once per `CLKS_PER_BIT` clocks, which puts every sample near the centre of its bit. Set `CLKS_PER_BIT` to the clock frequency divided by the bit rate; a 50 MHz clock at 115200 bit/s gives 434. At the stop-bit sample the receiver reports one result, as single-cycle strobes together with the byte. The data output is valid/ready-shaped but has no ready input, because a serial line cannot be held off. A consumer that misses the `rx_valid` cycle can still read `rx_data` until the next frame ends, but the strobe itself is not repeated.

Top module: `uart_oddpar_rx`

## Requirements
- R1: In the cycle after any clock edge where `rst` is high, `rx_valid`, `rx_parity_err` and `rx_frame_err` are low and `rx_data` is 0x00.
- R2: Data bits are assembled least significant first: the first bit after the start bit becomes `rx_data[0]` and the eighth becomes `rx_data[7]`.
- R3: A frame is accepted when its stop bit is high and the data bits plus the parity bit contain an odd number of ones. Examples: 0x00 with parity 1, and 0x07 with parity 0.
- R4: If a frame's ones count is even, `rx_parity_err` pulses for one cycle and `rx_valid` stays low for that frame.
- R5: If the stop bit is sampled low, `rx_frame_err` pulses for one cycle and `rx_valid` stays low for that frame.
- R6: If the line is back high when sampled half a bit after the start edge, the receiver treats it as a false start. It returns to idle with no strobe of any kind, and the next proper frame is received normally.
- R7: Each result strobe is high for exactly one cycle. With the start edge first seen low by the first synchronizer flop at edge t0, the strobe is visible in the cycle after edge t0 + SYNC_STAGES + CLKS_PER_BIT/2 + 10*CLKS_PER_BIT.
- R8: A frame whose start bit follows the previous stop bit with no idle gap is received correctly.
- R9: `rx_data` changes only on a cycle in which a result strobe is raised, and otherwise holds the last byte received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Byte from the last completed frame |
| rx_valid | output | 1 | One-cycle strobe: byte good |
| rx_parity_err | output | 1 | One-cycle strobe: parity check failed |
| rx_frame_err | output | 1 | One-cycle strobe: stop bit was low |

## Verification
Every result of this block appears at one fixed cycle after the start edge. The line passes through two synchronizer flops, the start bit is confirmed after half a bit, and ten full bit periods follow; the registered strobe adds one more edge. The bench therefore notes the cycle number when it drives the start bit and expects the strobe exactly 171 cycles later, with its divisor set to 16. A negedge monitor records the cycle and the data of every strobe, and counts how many cycles each strobe is high. Each task compares those records against its own frame once the frame has been sent, so a result one cycle early or late, or a strobe two cycles long, is caught.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // True when the data bits plus the parity bit hold an odd count of ones
  function automatic logic odd_ones(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/uart_oddpar_rx.sv
module uart_oddpar_rx #(
  parameter int CLKS_PER_BIT = 434,
  parameter int DATA_BITS    = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_parity_err,
  output logic                 rx_frame_err
);
  import uart_rx_pkg::*;

  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int IW   = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] LAST_IX = IW'(DATA_BITS - 1);

  logic                 rx_s;
  logic                 tick;
  logic                 ld;
  logic [CW-1:0]        ld_val;
  rx_state_t            state;
  logic [IW-1:0]        bit_ix;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_bit;
  logic                 ok_par;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .dout(rx_s)
  );

  uart_rx_bit_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (ld),
    .load_val(ld_val),
    .tick    (tick)
  );

  // Timer reload: half a bit on the start edge, a full bit after each sample
  always_comb begin
    ld     = 1'b0;
    ld_val = FULL_M1;
    unique case (state)
      RX_IDLE: if (!rx_s) begin
        ld     = 1'b1;
        ld_val = HALF_M1;
      end
      RX_START: ld = tick && !rx_s;
      RX_DATA:  ld = tick;
      RX_PAR:   ld = tick;
      default:  ld = 1'b0;
    endcase
  end

  assign ok_par = ^{shreg, par_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RX_IDLE;
      bit_ix        <= '0;
      shreg         <= '0;
      par_bit       <= 1'b0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
    end else begin
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      unique case (state)
        RX_IDLE: if (!rx_s) state <= RX_START;
        RX_START: if (tick) begin
          if (!rx_s) begin
            state  <= RX_DATA;
            bit_ix <= '0;
          end else begin
            state  <= RX_IDLE;
          end
        end
        RX_DATA: if (tick) begin
          shreg <= {rx_s, shreg[DATA_BITS-1:1]};
          if (bit_ix == LAST_IX) state <= RX_PAR;
          else                   bit_ix <= bit_ix + 1'b1;
        end
        RX_PAR: if (tick) begin
          par_bit <= rx_s;
          state   <= RX_STOP;
        end
        RX_STOP: if (tick) begin
          rx_data       <= shreg;
          rx_valid      <= ok_par && rx_s;
          rx_parity_err <= !ok_par;
          rx_frame_err  <= !rx_s;
          state         <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_oddpar_rx_checker.sv
module uart_oddpar_rx_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 rx_parity_err,
  input logic                 rx_frame_err
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_parity_err && !rx_frame_err && rx_data == '0));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_perr_single_R4: assert property (@(posedge clk) disable iff (rst)
    rx_parity_err |=> !rx_parity_err);

  assert_perr_no_valid_R4: assert property (@(posedge clk) disable iff (rst)
    rx_parity_err |-> !rx_valid);

  assert_ferr_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |=> !rx_frame_err);

  assert_ferr_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |-> !rx_valid);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid || rx_parity_err || rx_frame_err) |-> $stable(rx_data));
endmodule

bind uart_oddpar_rx uart_oddpar_rx_checker #(.DATA_BITS(DATA_BITS)) u_checker (
  .clk          (clk),
  .rst          (rst),
  .rx_data      (rx_data),
  .rx_valid     (rx_valid),
  .rx_parity_err(rx_parity_err),
  .rx_frame_err (rx_frame_err)
);

// File: tb/tb_uart_oddpar_rx.sv
`timescale 1ns/1ps
module tb_uart_oddpar_rx;
  localparam int CPB     = 16;
  localparam int LATENCY = 2 + CPB/2 + 10*CPB + 1; // from start-drive negedge

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_parity_err, rx_frame_err;

  int total = 0, bad = 0;
  int cyc = 0;
  int n_valid = 0, n_perr = 0, n_ferr = 0;
  int t_valid = -1, t_perr = -1, t_ferr = -1;
  logic [7:0] d_last = 8'h00;

  always #2.5 clk = ~clk;

  uart_oddpar_rx #(.CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid)      begin n_valid++; t_valid = cyc; d_last = rx_data; end
      if (rx_parity_err) begin n_perr++;  t_perr  = cyc; end
      if (rx_frame_err)  begin n_ferr++;  t_ferr  = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic par, input logic stopb,
                            output int cs);
    @(negedge clk);
    cs = cyc;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(par);
    drive_bit(stopb);
    rx_line = 1'b1;
  endtask

  // Good frame: valid once at the computed cycle with the right byte
  task automatic good_frame(input logic [7:0] b, input string req);
    int cs, v0, p0, f0;
    v0 = n_valid; p0 = n_perr; f0 = n_ferr;
    send_frame(b, ~^b, 1'b1, cs);
    chk(n_valid == v0 + 1, req, n_valid - v0, 1);
    chk(t_valid == cs + LATENCY, {req, "/R7 timing"}, t_valid, cs + LATENCY);
    chk(d_last == b, req, d_last, b);
    chk(n_perr == p0 && n_ferr == f0, req, n_perr - p0 + n_ferr - f0, 0);
  endtask

  task automatic t_reset;
    chk(rx_valid == 0 && rx_parity_err == 0 && rx_frame_err == 0, "R1 strobes",
        {rx_valid, rx_parity_err, rx_frame_err}, 0);
    chk(rx_data == 8'h00, "R1 data", rx_data, 0);
  endtask

  task automatic t_parity_err;
    int cs, v0, p0;
    v0 = n_valid; p0 = n_perr;
    send_frame(8'h3C, ^8'h3C, 1'b1, cs);  // even ones count
    chk(n_perr == p0 + 1, "R4 perr pulse", n_perr - p0, 1);
    chk(t_perr == cs + LATENCY, "R4/R7 perr timing", t_perr, cs + LATENCY);
    chk(n_valid == v0, "R4 no valid", n_valid - v0, 0);
    chk(rx_data == 8'h3C, "R9 data on perr", rx_data, 8'h3C);
  endtask

  task automatic t_frame_err;
    int cs, v0, f0;
    v0 = n_valid; f0 = n_ferr;
    send_frame(8'h5A, ~^8'h5A, 1'b0, cs);
    repeat (3*CPB) @(negedge clk);
    chk(n_ferr == f0 + 1, "R5 ferr pulse", n_ferr - f0, 1);
    chk(t_ferr == cs + LATENCY, "R5/R7 ferr timing", t_ferr, cs + LATENCY);
    chk(n_valid == v0, "R5 no valid", n_valid - v0, 0);
  endtask

  task automatic t_false_start;
    int v0, p0, f0;
    logic [7:0] dh;
    v0 = n_valid; p0 = n_perr; f0 = n_ferr; dh = rx_data;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (12*CPB) @(negedge clk);
    chk(n_valid == v0 && n_perr == p0 && n_ferr == f0, "R6 no strobe",
        n_valid - v0 + n_perr - p0 + n_ferr - f0, 0);
    chk(rx_data == dh, "R6/R9 data held", rx_data, dh);
    good_frame(8'hC3, "R6 recover");
  endtask

  task automatic t_back_to_back;
    good_frame(8'h12, "R8 first");
    good_frame(8'hED, "R8 second");
  endtask

  initial begin
    repeat (20_000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    repeat (10) @(negedge clk);
    good_frame(8'h00, "R3 zero byte");
    good_frame(8'h07, "R3 0x07");
    good_frame(8'h01, "R2 lsb");
    good_frame(8'h80, "R2 msb");
    good_frame(8'hFF, "R3 all ones");
    t_parity_err();
    t_frame_err();
    t_false_start();
    t_back_to_back();
    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule